// File: doc/BRIEF.md
# DSD Stream Validity Monitor

This block watches a one-bit oversampled audio stream, taking one data bit on each cycle where the sample strobe is high. It looks for two kinds of damage. A stuck stream is a long run of the same bit. A skewed stream is a recent stretch of bits where one value far outnumbers the other. A stuck stream raises a mute request toward the converter. A skewed stream raises an attenuate request. Each detector is switched on or off by its own enable input.

Two pieces of logic read the same incoming bits. The first is a sliding window of the last `WIN` bits with a running count of ones. The second, which can be chosen by parameter, is a run-length counter. The skew test always uses the window count. The stuck test uses either the window count or the run counter. A fill tracker keeps both requests low until a full window of bits has arrived since reset. A registered two-bit status word summarises the channel. The attenuation arithmetic and any mute-pin delay policy sit downstream and are not part of this block.

Top module: `dsd_stream_mon`

## Requirements
- R1: With `static_en` high at the strobe, `mute_req` is high from the clock cycle after the strobe that delivers the `WIN`-th (default 28) consecutive identical bit. The bits may be all zeros or all ones. A single differing bit anywhere in the last `WIN` bits keeps it low.
- R2: With `invalid_en` high at the strobe, `atten_req` is high from the cycle after any strobe where more than `INV_THRESH` (default 24) of the last `WIN` bits share one value, ones or zeros. Exactly `INV_THRESH` of one value is not enough.
- R3: A request whose enable is low at a strobe is low after that strobe, whatever the bits. Enabling or disabling takes effect at the next strobe.
- R4: A raised request falls in the cycle after the first strobe at which its condition no longer holds.
- R5: Both requests stay low until `WIN` strobes have been accepted since reset, even if every bit so far is equal.
- R6: Data and enables are sampled only when `smp_stb` is high. With the strobe low, `mute_req`, `atten_req` and `status` do not change, whatever the other inputs do.
- R7: `status` is updated at each strobe. It is 0 while fewer than `WIN` bits have arrived, 3 when `mute_req` is high, 2 when only `atten_req` is high, and 1 otherwise.
- R8: While `rst_n` is low, `mute_req` and `atten_req` are 0 and `status` is 0.
- R9: A stuck stream also satisfies the skew condition, so with both enables high a stuck stream raises both requests together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_stb | input | 1 | Sample strobe; one stream bit per high cycle |
| smp_bit | input | 1 | Stream data bit |
| static_en | input | 1 | Enable for the stuck-stream detector |
| invalid_en | input | 1 | Enable for the skewed-stream detector |
| mute_req | output | 1 | Mute request (stuck stream) |
| atten_req | output | 1 | Attenuate request (skewed stream) |
| status | output | 2 | Channel status: 0 filling, 1 clean, 2 skewed, 3 stuck |

## Verification
Several properties are checked on every cycle:
- the outputs hold still on cycles without a strobe;
- the requests stay quiet and the status reads filling until a full window of strobes has been counted independently;
- a request can only rise after a strobe that carried its enable;
- a stuck result with the skew detector enabled carries an attenuate request with it.

Only the bench's scenarios can show the exact thresholds. These include 24 versus 25 dominant bits, a single stray bit that breaks a run, the release of a request once the window slides past the offending bits, and the correct status under clean alternating data.

// File: rtl/dsd_mon_pkg.sv
package dsd_mon_pkg;

   typedef enum logic [1:0] {
      MON_FILL   = 2'd0,
      MON_CLEAN  = 2'd1,
      MON_SKEW   = 2'd2,
      MON_STATIC = 2'd3
   } mon_state_e;

   // Stuck-detector source selection
   localparam int unsigned SRC_WINDOW = 0;
   localparam int unsigned SRC_RUN    = 1;

   function automatic int unsigned tally_width(input int unsigned depth);
      return $clog2(depth + 1);
   endfunction

endpackage

// File: rtl/dsd_win_tally.sv
// Sliding window of the last WIN bits with a running count of ones.
module dsd_win_tally #(
   parameter int unsigned WIN = 28,
   parameter int unsigned CW  = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          stb,
   input  logic          bit_in,
   output logic [CW-1:0] ones_nxt
);

   logic [WIN-1:0] hist_q;
   logic [CW-1:0]  ones_q;
   logic           leave_bit;

   // Oldest bit sits at the top; it leaves as a new bit enters at the bottom.
   assign leave_bit = hist_q[WIN-1];

   always_comb begin
      if (stb) begin
         ones_nxt = ones_q + CW'(bit_in) - CW'(leave_bit);
      end else begin
         ones_nxt = ones_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q <= '0;
         ones_q <= '0;
      end else if (stb) begin
         hist_q <= {hist_q[WIN-2:0], bit_in};
         ones_q <= ones_nxt;
      end
   end

endmodule

// File: rtl/dsd_fill_track.sv
// Counts accepted bits up to WIN and reports when the window holds real data.
module dsd_fill_track #(
   parameter int unsigned WIN = 28,
   parameter int unsigned CW  = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stb,
   output logic full_nxt
);

   localparam logic [CW-1:0] LIMIT   = CW'(WIN);
   localparam logic [CW-1:0] LIMIT_M = CW'(WIN - 1);

   logic [CW-1:0] seen_q;
   logic          full_q;

   assign full_q   = (seen_q == LIMIT);
   assign full_nxt = full_q || (stb && (seen_q == LIMIT_M));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q <= '0;
      end else if (stb && !full_q) begin
         seen_q <= seen_q + 1'b1;
      end
   end

endmodule

// File: rtl/dsd_run_track.sv
// Length of the current run of identical bits, saturating at WIN.
module dsd_run_track #(
   parameter int unsigned WIN = 28,
   parameter int unsigned CW  = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stb,
   input  logic bit_in,
   output logic run_full_nxt
);

   localparam logic [CW-1:0] LIMIT = CW'(WIN);

   logic [CW-1:0] run_q;
   logic [CW-1:0] run_nxt;
   logic          last_q;

   always_comb begin
      run_nxt = run_q;
      if (stb) begin
         if ((run_q != '0) && (bit_in == last_q)) begin
            run_nxt = (run_q == LIMIT) ? LIMIT : run_q + 1'b1;
         end else begin
            run_nxt = CW'(1);
         end
      end
   end

   assign run_full_nxt = (run_nxt == LIMIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= '0;
         last_q <= 1'b0;
      end else if (stb) begin
         run_q  <= run_nxt;
         last_q <= bit_in;
      end
   end

endmodule

// File: rtl/dsd_stream_mon.sv
module dsd_stream_mon
   import dsd_mon_pkg::*;
#(
   parameter int unsigned WIN        = 28,
   parameter int unsigned INV_THRESH = 24,
   parameter int unsigned STATIC_SRC = SRC_WINDOW
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       smp_stb,
   input  logic       smp_bit,
   input  logic       static_en,
   input  logic       invalid_en,
   output logic       mute_req,
   output logic       atten_req,
   output logic [1:0] status
);

   localparam int unsigned   CW    = tally_width(WIN);
   localparam logic [CW-1:0] WIN_C = CW'(WIN);
   localparam logic [CW-1:0] THR_C = CW'(INV_THRESH);

   // Elaboration-time parameter checks
   generate
      if (WIN < 2) begin : g_bad_win
         $error("dsd_stream_mon: WIN must be at least 2");
      end
      if (INV_THRESH >= WIN) begin : g_bad_thr
         $error("dsd_stream_mon: INV_THRESH must be below WIN");
      end
      if ((2 * INV_THRESH + 1) < WIN) begin : g_overlap
         $error("dsd_stream_mon: INV_THRESH too small, ones and zeros could both dominate");
      end
      if (STATIC_SRC > SRC_RUN) begin : g_bad_src
         $error("dsd_stream_mon: STATIC_SRC must be SRC_WINDOW or SRC_RUN");
      end
   endgenerate

   logic [CW-1:0] ones_nxt;
   logic [CW-1:0] zeros_nxt;
   logic          full_nxt;
   logic          stuck_nxt;
   logic          skew_nxt;
   logic          mute_d;
   logic          atten_d;
   mon_state_e    state_d;
   mon_state_e    state_q;

   dsd_win_tally #(.WIN(WIN), .CW(CW)) u_tally (
      .clk      (clk),
      .rst_n    (rst_n),
      .stb      (smp_stb),
      .bit_in   (smp_bit),
      .ones_nxt (ones_nxt)
   );

   dsd_fill_track #(.WIN(WIN), .CW(CW)) u_fill (
      .clk      (clk),
      .rst_n    (rst_n),
      .stb      (smp_stb),
      .full_nxt (full_nxt)
   );

   assign zeros_nxt = WIN_C - ones_nxt;
   assign skew_nxt  = (ones_nxt > THR_C) || (zeros_nxt > THR_C);

   generate
      if (STATIC_SRC == SRC_RUN) begin : g_stuck_run
         logic run_full_nxt;
         dsd_run_track #(.WIN(WIN), .CW(CW)) u_run (
            .clk          (clk),
            .rst_n        (rst_n),
            .stb          (smp_stb),
            .bit_in       (smp_bit),
            .run_full_nxt (run_full_nxt)
         );
         assign stuck_nxt = run_full_nxt;
      end else begin : g_stuck_win
         assign stuck_nxt = (ones_nxt == '0) || (ones_nxt == WIN_C);
      end
   endgenerate

   assign mute_d  = static_en  && full_nxt && stuck_nxt;
   assign atten_d = invalid_en && full_nxt && skew_nxt;

   always_comb begin
      if (!full_nxt) begin
         state_d = MON_FILL;
      end else if (mute_d) begin
         state_d = MON_STATIC;
      end else if (atten_d) begin
         state_d = MON_SKEW;
      end else begin
         state_d = MON_CLEAN;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mute_req  <= 1'b0;
         atten_req <= 1'b0;
         state_q   <= MON_FILL;
      end else if (smp_stb) begin
         mute_req  <= mute_d;
         atten_req <= atten_d;
         state_q   <= state_d;
      end
   end

   assign status = state_q;

endmodule

// File: rtl/dsd_mon_chk.sv
module dsd_mon_chk #(
   parameter int unsigned WIN = 28
) (
   input logic       clk,
   input logic       rst_n,
   input logic       smp_stb,
   input logic       static_en,
   input logic       invalid_en,
   input logic       mute_req,
   input logic       atten_req,
   input logic [1:0] status
);

   localparam int unsigned CW = $clog2(WIN + 1);

   logic [CW-1:0] seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen <= '0;
      end else if (smp_stb && (seen != CW'(WIN))) begin
         seen <= seen + 1'b1;
      end
   end

   // R5: no request before a full window has arrived
   assert_fill_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (seen < CW'(WIN)) |-> (!mute_req && !atten_req));

   // R7: status reads filling exactly until a full window
   assert_fill_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((seen < CW'(WIN)) |-> (status == 2'd0)) and
      ((seen == CW'(WIN)) |-> (status != 2'd0)));

   // R3: a request only rises after a strobe that carried its enable
   assert_mute_enabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mute_req) |-> $past(smp_stb && static_en));

   assert_atten_enabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(atten_req) |-> $past(smp_stb && invalid_en));

   // R6: outputs hold when no strobe was seen
   assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(smp_stb) |-> ($stable(mute_req) && $stable(atten_req) && $stable(status)));

   // R9: a stuck stream with the skew detector enabled also attenuates
   assert_stuck_skews_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(smp_stb) && $past(invalid_en) && mute_req) |-> atten_req);

endmodule

bind dsd_stream_mon dsd_mon_chk #(.WIN(WIN)) u_mon_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .smp_stb    (smp_stb),
   .static_en  (static_en),
   .invalid_en (invalid_en),
   .mute_req   (mute_req),
   .atten_req  (atten_req),
   .status     (status)
);

// File: tb/dsd_stream_mon_bench.sv
module dsd_stream_mon_bench;

   localparam int WIN = 28;
   localparam int THR = 24;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       smp_stb = 1'b0;
   logic       smp_bit = 1'b0;
   logic       static_en = 1'b1;
   logic       invalid_en = 1'b0;
   logic       mute_req;
   logic       atten_req;
   logic [1:0] status;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   // reference state
   bit hist[WIN];
   int nrecv;
   bit exp_mute, exp_atten;
   logic [1:0] exp_status;

   always #4 clk = ~clk;

   dsd_stream_mon u_dsd_stream_mon (
      .clk        (clk),
      .rst_n      (rst_n),
      .smp_stb    (smp_stb),
      .smp_bit    (smp_bit),
      .static_en  (static_en),
      .invalid_en (invalid_en),
      .mute_req   (mute_req),
      .atten_req  (atten_req),
      .status     (status)
   );

   task automatic compare(input string tag);
      n_cmp++;
      if (mute_req !== exp_mute || atten_req !== exp_atten || status !== exp_status) begin
         n_bad++;
         $display("FAIL %s: got mute=%b atten=%b status=%0d expected mute=%b atten=%b status=%0d",
                  tag, mute_req, atten_req, status, exp_mute, exp_atten, exp_status);
      end
   endtask

   task automatic model_clear();
      for (int i = 0; i < WIN; i++) hist[i] = 0;
      nrecv = 0;
      exp_mute = 0;
      exp_atten = 0;
      exp_status = 2'd0;
   endtask

   task automatic model_step(input bit b, input bit sen, input bit ien);
      int ones;
      bit full;
      for (int i = WIN - 1; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = b;
      nrecv++;
      ones = 0;
      for (int i = 0; i < WIN; i++) ones += hist[i];
      full = (nrecv >= WIN);
      exp_mute  = full && sen && (ones == 0 || ones == WIN);
      exp_atten = full && ien && (ones > THR || (WIN - ones) > THR);
      if (!full)          exp_status = 2'd0;
      else if (exp_mute)  exp_status = 2'd3;
      else if (exp_atten) exp_status = 2'd2;
      else                exp_status = 2'd1;
   endtask

   task automatic send(input bit b, input string tag);
      @(negedge clk);
      smp_stb = 1'b1;
      smp_bit = b;
      model_step(b, static_en, invalid_en);
      @(negedge clk);
      smp_stb = 1'b0;
      compare(tag);
   endtask

   task automatic do_reset(input string tag);
      @(negedge clk);
      rst_n = 1'b0;
      smp_stb = 1'b0;
      model_clear();
      repeat (2) @(negedge clk);
      compare(tag);
      rst_n = 1'b1;
      @(negedge clk);
      compare(tag);
   endtask

   // R8 / R7: reset state
   task automatic t_reset();
      do_reset("R8 reset state");
   endtask

   // R5, R1, R9, R4: all-ones fill, stuck detection, then break
   task automatic t_fill_stuck();
      do_reset("R8 reset");
      static_en = 1'b1;
      invalid_en = 1'b1;
      for (int i = 0; i < WIN - 1; i++) send(1'b1, "R5 quiet while filling");
      send(1'b1, "R1 stuck ones at 28th bit");
      if (!(mute_req && atten_req)) begin
         n_bad++;
         $display("FAIL R9: got mute=%b atten=%b expected mute=1 atten=1", mute_req, atten_req);
      end
      n_cmp++;
      send(1'b0, "R4 mute releases on stray bit");
   endtask

   // R2: threshold at 24 versus 25 dominant ones
   task automatic t_threshold();
      do_reset("R8 reset");
      static_en = 1'b0;
      invalid_en = 1'b1;
      for (int i = 0; i < 4; i++) send(1'b0, "R5 filling");
      for (int i = 0; i < 23; i++) send(1'b1, "R5 filling");
      send(1'b1, "R2 exactly 24 ones is not skewed");
      send(1'b1, "R2 25 ones is skewed");
      for (int i = 0; i < 4; i++) send(1'b0, "R4 skew releases as zeros enter");
   endtask

   // R2: zero-dominated window
   task automatic t_zero_skew();
      do_reset("R8 reset");
      static_en = 1'b1;
      invalid_en = 1'b1;
      for (int i = 0; i < 25; i++) send(1'b0, "R5 filling");
      for (int i = 0; i < 2; i++) send(1'b1, "R5 filling");
      send(1'b1, "R2 25 zeros is skewed");
      for (int i = 0; i < 30; i++) send(1'b0, "R1 stuck zeros after window slides");
   endtask

   // R1: a single differing bit in the window blocks the stuck result
   task automatic t_run_break();
      do_reset("R8 reset");
      static_en = 1'b1;
      invalid_en = 1'b0;
      for (int i = 0; i < 20; i++) send(1'b1, "R5 filling");
      send(1'b0, "R5 filling");
      for (int i = 0; i < 27; i++) send(1'b1, "R1 run broken by one zero");
      send(1'b1, "R1 28 ones after the stray bit");
   endtask

   // R3: enables gate requests at the strobe
   task automatic t_enables();
      do_reset("R8 reset");
      static_en = 1'b0;
      invalid_en = 1'b0;
      for (int i = 0; i < 32; i++) send(1'b0, "R3 both disabled");
      static_en = 1'b1;
      send(1'b0, "R3 static enabled");
      invalid_en = 1'b1;
      send(1'b0, "R3 invalid enabled");
      static_en = 1'b0;
      send(1'b0, "R3 static disabled");
      invalid_en = 1'b0;
      send(1'b0, "R3 invalid disabled");
   endtask

   // R6: no strobe, no change
   task automatic t_idle();
      do_reset("R8 reset");
      static_en = 1'b1;
      invalid_en = 1'b1;
      for (int i = 0; i < WIN; i++) send(1'b0, "R1 stuck zeros");
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         smp_bit = ~smp_bit;
         static_en = i[0];
         invalid_en = i[1];
         @(negedge clk);
         compare("R6 idle cycles hold outputs");
      end
      static_en = 1'b1;
      invalid_en = 1'b1;
   endtask

   // R7: clean alternating data
   task automatic t_clean();
      do_reset("R8 reset");
      static_en = 1'b1;
      invalid_en = 1'b1;
      for (int i = 0; i < 40; i++) send(i[0], "R7 alternating stream is clean");
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      model_clear();
      t_reset();
      t_fill_stuck();
      t_threshold();
      t_zero_skew();
      t_run_break();
      t_enables();
      t_idle();
      t_clean();
      done = 1;
      summary();
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got no completion expected completion");
         summary();
         $finish;
      end
   end

endmodule